// File: doc/BRIEF.md
# Host-to-Slave Bidirectional Mailbox Port

This block passes single bytes in both directions between a host bus and a slave I/O processor. The host sees four consecutive I/O addresses. Their base comes from a six-bit jumper field. Through these addresses the host can:

- write bytes for the slave;
- read bytes the slave has left;
- read a flag register;
- issue a control write, which either changes one flag bit or clears the whole mailbox.

The slave side has three parts:

- a byte input bus, with an active-low strobe that loads the byte into the inbound latch;
- an active-low acknowledge that puts the outbound latch onto the shared bus, through a data/enable pair that feeds a tri-state driver;
- a status byte that the slave can read at any time.

Two interrupt enables control an interrupt request toward the host. The host also drives two fixed-meaning flags. One tags the mailbox byte as a command or as data. The other holds the slave in reset.

All state changes happen on the rising clock edge. The data output, its enable, the interrupt request, the status byte and the host read data are combinational functions of the current state and the current inputs.

Top module: `host_slave_mailbox`

## Requirements
- R1: The block responds only when host address bits 7..2 equal `jumper_n`, where a 1 means an open jumper and a 0 means an installed one. Any other address reads back 0 and its writes change nothing.
- R2: While `slave_stb_n` is low at a clock edge, the inbound latch takes `slave_din` and the in-full flag sets. A host read of offset 0 returns the inbound latch and clears the in-full flag at that edge.
- R3: A host write to offset 0 stores the byte in the outbound latch, and the out-full flag (active low) goes low at that edge.
- R4: While `slave_ack_n` is low, `slave_doe` is 1 and `slave_dout` equals the outbound latch; otherwise `slave_doe` is 0. On the first edge where `slave_ack_n` is high after being low, the out-full flag returns high.
- R5: A host write to offset 3 with bit 7 = 0 sets or clears one flag. Bits 3..1 select the flag and bit 0 gives its value:
  - select 0 is the command/data flag;
  - select 1 is the slave reset;
  - select 4 is the inbound interrupt enable;
  - select 6 is the outbound interrupt enable;
  - any other select has no effect.
- R6: `intr` is 1 exactly when the inbound enable and the in-full flag are both set, or when the outbound enable is set and the out-full flag (active low) is high.
- R7: A host read of offset 2 returns the flag register, with unused bit 2 reading 0:

  | Bit | Content |
  |-----|---------|
  | 7 | out-full (active low) |
  | 6 | outbound enable |
  | 5 | in-full |
  | 4 | inbound enable |
  | 3 | intr |
  | 1 | slave reset |
  | 0 | command/data flag |

- R8: `slave_status` holds the out-full flag (active low) in bit 6, the in-full flag in bit 5 and the command/data flag in bit 4. All other bits are 0.
- R9: A host write to offset 3 with bit 7 = 1 clears both latches, sets the in-full flag to 0 and the out-full flag (active low) to 1, and clears both enables. The command/data flag and the slave reset keep their values.
- R10: After reset, both latches and all flags are clear, the out-full flag (active low) is high, `slave_reset` is 0 and `slave_doe` is 0.
- R11: Reads of offset 1 and offset 3 return 0. Host writes to offset 1 and offset 2 have no effect.
- R12: When a strobe and a host read of offset 0 fall on the same edge, the in-full flag stays set. When a host write to offset 0 coincides with the acknowledge release, the out-full flag (active low) goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| jumper_n | input | AW-2 | Base address jumpers, 1 = open |
| host_addr | input | AW | Host I/O address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| intr | output | 1 | Interrupt request to host |
| slave_stb_n | input | 1 | Slave strobe, loads the inbound latch |
| slave_ack_n | input | 1 | Slave acknowledge, enables the outbound drive |
| slave_din | input | 8 | Shared bus value as seen by this block |
| slave_dout | output | 8 | Outbound latch onto the shared bus |
| slave_doe | output | 1 | Tri-state enable for slave_dout |
| slave_status | output | 8 | Flag byte read by the slave |
| slave_reset | output | 1 | Reset line to the slave |
| cmd_flag | output | 1 | Command/data tag for the mailbox byte |

## Verification
The embedded assertions check the edge-level effects on every cycle:

- a strobe sets the in-full flag, and a host read clears it when no strobe is present;
- a host byte write drops the out-full flag, and the acknowledge release raises it;
- a mode write empties both sides and leaves the interrupt request low.

Other behaviours are visible only in the bench's scenarios against its cycle model:

- address decoding against the jumper field;
- the bit layout of the flag register and the status byte;
- the effect of each set/reset select, including the selects that must do nothing;
- the interrupt request that builds up as enables and flags combine;
- the two same-edge priority cases.

// File: rtl/host_slave_mailbox.sv
module host_slave_mailbox #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-3:0] jumper_n,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          intr,
  input  logic          slave_stb_n,
  input  logic          slave_ack_n,
  input  logic [7:0]    slave_din,
  output logic [7:0]    slave_dout,
  output logic          slave_doe,
  output logic [7:0]    slave_status,
  output logic          slave_reset,
  output logic          cmd_flag
);

  localparam logic [1:0] OFS_A = 2'd0, OFS_C = 2'd2, OFS_CTL = 2'd3;

  logic [7:0] in_lat, out_lat;
  logic       ibf, obf_n, inte_in, inte_out, ack_q;

  wire       sel     = host_addr[AW-1:2] == jumper_n;
  wire [1:0] ofs     = host_addr[1:0];
  wire       wr_a    = host_wr & sel & (ofs == OFS_A);
  wire       rd_a    = host_rd & sel & (ofs == OFS_A);
  wire       ctl_wr  = host_wr & sel & (ofs == OFS_CTL);
  wire       mode_wr = ctl_wr & host_wdata[7];
  wire       bsr_wr  = ctl_wr & ~host_wdata[7];
  wire       ack_up  = ~ack_q & slave_ack_n;

  assign intr         = (inte_out & obf_n) | (inte_in & ibf);
  assign slave_dout   = out_lat;
  assign slave_doe    = ~slave_ack_n;
  assign slave_status = {1'b0, obf_n, ibf, cmd_flag, 4'b0};

  wire [7:0] port_c = {obf_n, inte_out, ibf, inte_in, intr, 1'b0, slave_reset, cmd_flag};

  always_comb begin
    host_rdata = '0;
    if (host_rd && sel)
      case (ofs)
        OFS_A:   host_rdata = in_lat;
        OFS_C:   host_rdata = port_c;
        default: host_rdata = '0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_lat      <= '0;
      out_lat     <= '0;
      ibf         <= 1'b0;
      obf_n       <= 1'b1;
      inte_in     <= 1'b0;
      inte_out    <= 1'b0;
      cmd_flag    <= 1'b0;
      slave_reset <= 1'b0;
      ack_q       <= 1'b1;
    end else begin
      ack_q <= slave_ack_n;
      if (mode_wr) begin
        in_lat   <= '0;
        out_lat  <= '0;
        ibf      <= 1'b0;
        obf_n    <= 1'b1;
        inte_in  <= 1'b0;
        inte_out <= 1'b0;
      end else begin
        if (!slave_stb_n) begin
          in_lat <= slave_din;
          ibf    <= 1'b1;
        end else if (rd_a) begin
          ibf <= 1'b0;
        end
        if (wr_a) begin
          out_lat <= host_wdata;
          obf_n   <= 1'b0;
        end else if (ack_up) begin
          obf_n <= 1'b1;
        end
        if (bsr_wr)
          case (host_wdata[3:1])
            3'd0:    cmd_flag    <= host_wdata[0];
            3'd1:    slave_reset <= host_wdata[0];
            3'd4:    inte_in     <= host_wdata[0];
            3'd6:    inte_out    <= host_wdata[0];
            default: ;
          endcase
      end
    end
  end

  AST_STB_SETS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_stb_n && !mode_wr) |=> ibf); // R2
  AST_READ_CLEARS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a && slave_stb_n) |=> !ibf); // R2
  AST_WRITE_FILLS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && !mode_wr) |=> !obf_n); // R3
  AST_ACK_EMPTIES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(slave_ack_n) && !wr_a) |=> obf_n); // R4
  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (!ibf && obf_n && !intr && in_lat == 8'h00)); // R9

endmodule

// File: tb/host_slave_mailbox_bench.sv
`timescale 1ns/1ps
module host_slave_mailbox_bench;
  localparam logic [5:0] J = 6'b010000;
  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0, din = 0;
  logic wr = 0, rd = 0, stb_n = 1, ack_n = 1;
  wire [7:0] rdata, dout, status;
  wire intr, doe, srst, cflag;
  int checks = 0, fails = 0;

  host_slave_mailbox u_host_slave_mailbox (
    .clk(clk), .rst_n(rst_n), .jumper_n(J), .host_addr(addr), .host_wr(wr),
    .host_rd(rd), .host_wdata(wdata), .host_rdata(rdata), .intr(intr),
    .slave_stb_n(stb_n), .slave_ack_n(ack_n), .slave_din(din),
    .slave_dout(dout), .slave_doe(doe), .slave_status(status),
    .slave_reset(srst), .cmd_flag(cflag));

  always #4 clk = ~clk;

  // behavioural reference state
  logic [7:0] m_in = 0, m_out = 0;
  bit m_ibf = 0, m_full = 0, m_ie_in = 0, m_ie_out = 0, m_cmd = 0, m_srst = 0, m_ack_prev = 1;

  function automatic bit m_intr();
    return (m_ie_out && !m_full) || (m_ie_in && m_ibf);
  endfunction

  function automatic logic [7:0] m_rdata();
    if (!rd || addr[7:2] != J) return 8'h00;
    if (addr[1:0] == 2'd0) return m_in;
    if (addr[1:0] == 2'd2)
      return {!m_full, m_ie_out, m_ibf, m_ie_in, m_intr(), 1'b0, m_srst, m_cmd};
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    bit hit, released;
    hit = (addr[7:2] == J);
    released = m_ack_prev == 0 && ack_n == 1;
    m_ack_prev = ack_n;
    if (!rst_n) begin
      m_in = 0; m_out = 0; m_ibf = 0; m_full = 0; m_ie_in = 0; m_ie_out = 0;
      m_cmd = 0; m_srst = 0; m_ack_prev = 1;
    end else if (hit && wr && addr[1:0] == 3 && wdata[7]) begin
      m_in = 0; m_out = 0; m_ibf = 0; m_full = 0; m_ie_in = 0; m_ie_out = 0;
    end else begin
      bit rd_now;
      rd_now = hit && rd && addr[1:0] == 0;
      if (stb_n == 0) begin m_in = din; m_ibf = 1; end
      else if (rd_now) m_ibf = 0;
      if (hit && wr && addr[1:0] == 0) begin m_out = wdata; m_full = 1; end
      else if (released) m_full = 0;
      if (hit && wr && addr[1:0] == 3) begin
        int s;
        s = wdata[3:1];
        if (s == 0) m_cmd = wdata[0];
        if (s == 1) m_srst = wdata[0];
        if (s == 4) m_ie_in = wdata[0];
        if (s == 6) m_ie_out = wdata[0];
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      chk("R1 R2 R7 R11 rdata", rdata, m_rdata());
      chk("R6 intr", {7'b0, intr}, {7'b0, m_intr()});
      chk("R8 status", status, {1'b0, !m_full, m_ibf, m_cmd, 4'b0});
      chk("R4 doe", {7'b0, doe}, {7'b0, !ack_n});
      if (!ack_n) chk("R4 dout", dout, m_out);
      chk("R5 slave_reset", {7'b0, srst}, {7'b0, m_srst});
      chk("R5 cmd_flag", {7'b0, cflag}, {7'b0, m_cmd});
    end
  end

  task automatic hw(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic hr(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic strobe(logic [7:0] d);
    @(negedge clk); din = d; stb_n = 0;
    @(negedge clk); stb_n = 1;
  endtask

  task automatic ack();
    @(negedge clk); ack_n = 0;
    @(negedge clk); ack_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 status", status, 8'h40);
    chk("R10 doe/intr/srst", {5'b0, doe, intr, srst}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    // R3 host write, R4 ack
    hw(8'h40, 8'hA5);
    chk("R3 status after write", status, 8'h00);
    @(negedge clk); ack_n = 0; #1;
    chk("R4 drive", dout, 8'hA5);
    chk("R4 oe", {7'b0, doe}, 8'h01);
    @(negedge clk); ack_n = 1; @(negedge clk);
    chk("R4 release", status, 8'h40);
    // R2 inbound
    strobe(8'h3C);
    chk("R2 ibf set", status, 8'h60);
    hr(8'h40, v);
    chk("R2 read data", v, 8'h3C);
    chk("R2 ibf cleared", status, 8'h40);
    // R5 R6 inbound enable
    hw(8'h43, 8'h09);
    strobe(8'h11);
    chk("R6 intr inbound", {7'b0, intr}, 8'h01);
    hr(8'h40, v);
    chk("R6 intr drop", {7'b0, intr}, 8'h00);
    // R6 outbound enable
    hw(8'h43, 8'h0D);
    chk("R6 intr out empty", {7'b0, intr}, 8'h01);
    hw(8'h40, 8'h77);
    chk("R6 intr out full", {7'b0, intr}, 8'h00);
    ack();
    chk("R6 intr after ack", {7'b0, intr}, 8'h01);
    // R5 flags
    hw(8'h43, 8'h01);
    hw(8'h43, 8'h03);
    chk("R5 flags", {6'b0, srst, cflag}, 8'h03);
    hr(8'h42, v);
    chk("R7 port C", v, 8'hDB);
    hw(8'h43, 8'h05);
    hw(8'h43, 8'h0F);
    hr(8'h42, v);
    chk("R5 unused selects", v, 8'hDB);
    // R1 decode
    hw(8'h80, 8'h22);
    hr(8'h80, v);
    chk("R1 other address read", v, 8'h00);
    chk("R1 other address write", status, 8'h50);
    // R11
    hw(8'h41, 8'h55);
    hw(8'h42, 8'h00);
    hr(8'h41, v);
    chk("R11 port B read", v, 8'h00);
    hr(8'h43, v);
    chk("R11 ctl read", v, 8'h00);
    hr(8'h42, v);
    chk("R11 port C write ignored", v, 8'hDB);
    // R12 strobe vs read
    @(negedge clk); addr = 8'h40; rd = 1; din = 8'h99; stb_n = 0;
    @(negedge clk); rd = 0; stb_n = 1;
    chk("R12 strobe wins", status, 8'h70);
    // R12 write vs ack release
    @(negedge clk); ack_n = 0;
    @(negedge clk); ack_n = 1; addr = 8'h40; wdata = 8'h5A; wr = 1;
    @(negedge clk); wr = 0;
    chk("R12 write wins", status, 8'h30);
    // R9 mode write
    hw(8'h43, 8'h80);
    chk("R9 status", status, 8'h50);
    hr(8'h42, v);
    chk("R9 port C", v, 8'h83);
    hr(8'h40, v);
    chk("R9 in latch", v, 8'h00);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule